// File: doc/BRIEF.md
# Floating-Point Exception Flag Unit

This block holds the exception status word of a floating-point unit in a 32-bit core. Every completed floating-point operation reports its raised exceptions together with an instruction class. The block filters the report according to that class. Arithmetic operations pass all five exceptions. An ordered compare may only signal Invalid Operation, and only when its operands turned out unordered. An unordered compare is always silent.

The filtered result replaces the "last operation" field and is merged into the sticky "accrued" field. Software can read the whole word and rewrite the two flag fields. Five trap-enable bits, supplied from the status register, are matched against each newly raised set of flags. Any overlap produces a single-cycle trap request.

Top module: `fpx_flag_unit`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `rd_data` is all zeros and `trap_req` is low.
- R2: Inside each 5-bit flag field the bit order from high to low is Invalid Operation, Division by Zero, Overflow, Underflow, Inexact. When `op_valid` is high with `op_class` = 0 (arithmetic), the field at `rd_data[12:8]` becomes `op_exc` on the next clock, and any earlier content is lost.
- R3: The field at `rd_data[4:0]` is ORed with the filtered exceptions of every accepted operation. Its bits stay set until a software write changes them.
- R4: With `op_class` = 1 (ordered compare), the filtered exceptions are `{op_exc[4] & cmp_unord, 4'b0000}`. All other reported bits are discarded.
- R5: With `op_class` = 2 (unordered compare), with `op_class` = 3 (reserved), or with `op_valid` low, both fields keep their value and no trap is requested.
- R6: A write (`sw_wr` high) loads `sw_wdata[12:8]` into the last-operation field and `sw_wdata[4:0]` into the accrued field. `rd_data[31:13]` and `rd_data[7:5]` always read zero.
- R7: `trap_req` is high for exactly the cycle after an accepted operation whose filtered exceptions share a set bit with `trap_en` (bit 4 = Invalid … bit 0 = Inexact). In every other cycle it is low.
- R8: When a write and an accepted operation fall in the same cycle, each field takes the written value ORed with the operation's filtered exceptions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | A floating-point operation completes this cycle |
| op_class | input | 2 | 0 arithmetic, 1 ordered compare, 2 unordered compare, 3 reserved |
| op_exc | input | 5 | Reported exceptions, Invalid at bit 4 down to Inexact at bit 0 |
| cmp_unord | input | 1 | Compare result was unordered |
| trap_en | input | 5 | Trap enables from status register bits 12..8 |
| sw_wr | input | 1 | Software write strobe |
| sw_wdata | input | 32 | Software write data |
| rd_data | output | 32 | Registered exception word |
| trap_req | output | 1 | One-cycle trap request |

## Verification
An operation update and a software write can land on the same clock edge. The bench provokes this by raising `sw_wr` in the very cycle that `op_valid` carries an arithmetic or ordered-compare report. It then judges both fields against the written value ORed with the filtered exceptions. Separately, a full sweep of every exception pattern, every class and both unordered outcomes is scored against a model that the bench computes arithmetically.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  typedef enum logic [1:0] {
    FPX_ARITH     = 2'd0,
    FPX_CMP_ORD   = 2'd1,
    FPX_CMP_UNORD = 2'd2,
    FPX_CLS_RSVD  = 2'd3
  } fpx_class_e;
endpackage

// File: rtl/fpx_class_filter.sv
module fpx_class_filter
  import fpx_pkg::*;
#(
  parameter int unsigned NEXC = 5
) (
  input  logic             op_valid,
  input  fpx_class_e       op_class,
  input  logic [NEXC-1:0]  op_exc,
  input  logic             cmp_unord,
  output logic             upd,
  output logic [NEXC-1:0]  filt
);
  localparam int unsigned INV_BIT = NEXC - 1;

  always_comb begin
    upd  = 1'b0;
    filt = '0;
    if (op_valid) begin
      unique case (op_class)
        FPX_ARITH: begin
          upd  = 1'b1;
          filt = op_exc;
        end
        FPX_CMP_ORD: begin
          upd           = 1'b1;
          filt[INV_BIT] = op_exc[INV_BIT] & cmp_unord;
        end
        default: begin
          upd  = 1'b0;
          filt = '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/fpx_flag_regs.sv
module fpx_flag_regs #(
  parameter int unsigned NEXC = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd,
  input  logic [NEXC-1:0]  filt,
  input  logic             sw_wr,
  input  logic [NEXC-1:0]  sw_act,
  input  logic [NEXC-1:0]  sw_acc,
  output logic [NEXC-1:0]  act_q,
  output logic [NEXC-1:0]  acc_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= '0;
      acc_q <= '0;
    end else if (upd && sw_wr) begin
      act_q <= sw_act | filt;
      acc_q <= sw_acc | filt;
    end else if (upd) begin
      act_q <= filt;
      acc_q <= acc_q | filt;
    end else if (sw_wr) begin
      act_q <= sw_act;
      acc_q <= sw_acc;
    end
  end

  a_r3_accrued_sticky: assert property (@(posedge clk) disable iff (rst)
    !sw_wr |=> ((acc_q & $past(acc_q)) == $past(acc_q)));

  a_r5_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    (!upd && !sw_wr) |=> ($stable(act_q) && $stable(acc_q)));

  a_r2_actual_overwrite: assert property (@(posedge clk) disable iff (rst)
    (upd && !sw_wr) |=> (act_q == $past(filt)));

  a_r8_collision_merge: assert property (@(posedge clk) disable iff (rst)
    (upd && sw_wr) |=> ((act_q & $past(filt)) == $past(filt)
                        && (acc_q & $past(filt)) == $past(filt)));
endmodule

// File: rtl/fpx_trap_gen.sv
module fpx_trap_gen #(
  parameter int unsigned NEXC = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd,
  input  logic [NEXC-1:0]  filt,
  input  logic [NEXC-1:0]  trap_en,
  output logic             trap_req
);
  always_ff @(posedge clk) begin
    if (rst) trap_req <= 1'b0;
    else     trap_req <= upd && ((filt & trap_en) != '0);
  end

  a_r7_no_trap_without_update: assert property (@(posedge clk) disable iff (rst)
    !upd |=> !trap_req);
endmodule

// File: rtl/fpx_flag_unit.sv
module fpx_flag_unit
  import fpx_pkg::*;
#(
  parameter int unsigned NEXC    = 5,
  parameter int unsigned REG_W   = 32,
  parameter int unsigned ACT_LSB = 8,
  parameter int unsigned ACC_LSB = 0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               op_valid,
  input  logic [1:0]         op_class,
  input  logic [NEXC-1:0]    op_exc,
  input  logic               cmp_unord,
  input  logic [NEXC-1:0]    trap_en,
  input  logic               sw_wr,
  input  logic [REG_W-1:0]   sw_wdata,
  output logic [REG_W-1:0]   rd_data,
  output logic               trap_req
);
  localparam int unsigned INV_BIT = NEXC - 1;

  logic            upd;
  logic [NEXC-1:0] filt;
  logic [NEXC-1:0] act_q;
  logic [NEXC-1:0] acc_q;

  fpx_class_filter #(.NEXC(NEXC)) filter_i (
    .op_valid (op_valid),
    .op_class (fpx_class_e'(op_class)),
    .op_exc   (op_exc),
    .cmp_unord(cmp_unord),
    .upd      (upd),
    .filt     (filt)
  );

  fpx_flag_regs #(.NEXC(NEXC)) regs_i (
    .clk   (clk),
    .rst   (rst),
    .upd   (upd),
    .filt  (filt),
    .sw_wr (sw_wr),
    .sw_act(sw_wdata[ACT_LSB +: NEXC]),
    .sw_acc(sw_wdata[ACC_LSB +: NEXC]),
    .act_q (act_q),
    .acc_q (acc_q)
  );

  fpx_trap_gen #(.NEXC(NEXC)) trap_i (
    .clk     (clk),
    .rst     (rst),
    .upd     (upd),
    .filt    (filt),
    .trap_en (trap_en),
    .trap_req(trap_req)
  );

  always_comb begin
    rd_data = '0;
    rd_data[ACT_LSB +: NEXC] = act_q;
    rd_data[ACC_LSB +: NEXC] = acc_q;
  end

  a_r4_ordered_cmp_invalid_only: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_class == 2'd1) |-> (filt[INV_BIT-1:0] == '0));

  a_r5_silent_classes: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_class[1]) |-> !upd);

  a_r7_trap_has_cause: assert property (@(posedge clk) disable iff (rst)
    trap_req |-> (($past(filt) & $past(trap_en)) != '0));
endmodule

// File: tb/fpx_flag_unit_tb_top.sv
`timescale 1ns/1ps
module fpx_flag_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        op_valid;
  logic [1:0]  op_class;
  logic [4:0]  op_exc;
  logic        cmp_unord;
  logic [4:0]  trap_en;
  logic        sw_wr;
  logic [31:0] sw_wdata;
  logic [31:0] rd_data;
  logic        trap_req;

  int n_chk = 0;
  int n_bad = 0;
  logic [4:0] m_act = '0;
  logic [4:0] m_acc = '0;
  logic       m_trap = 1'b0;

  always #2.5 clk = ~clk;

  fpx_flag_unit dut_i (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_class(op_class),
    .op_exc(op_exc), .cmp_unord(cmp_unord), .trap_en(trap_en),
    .sw_wr(sw_wr), .sw_wdata(sw_wdata), .rd_data(rd_data), .trap_req(trap_req)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  // Drive one cycle at negedge, model it, check at the next negedge.
  task automatic step(input logic v, input logic [1:0] cls, input logic [4:0] e,
                      input logic u, input logic [4:0] te, input logic w,
                      input logic [31:0] wd, input string tag);
    logic [4:0] f;
    logic       up;
    op_valid = v; op_class = cls; op_exc = e; cmp_unord = u;
    trap_en = te; sw_wr = w; sw_wdata = wd;
    up = v && (cls == 2'd0 || cls == 2'd1);
    f  = !up ? 5'd0 : (cls == 2'd0) ? e : {e[4] & u, 4'b0000};
    if (up && w)      begin m_act = wd[12:8] | f; m_acc = wd[4:0] | f; end
    else if (up)      begin m_act = f; m_acc = m_acc | f; end
    else if (w)       begin m_act = wd[12:8]; m_acc = wd[4:0]; end
    m_trap = up && ((f & te) != 5'd0);
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0; sw_wr = 1'b0;
    check(tag, rd_data, {19'd0, m_act, 3'd0, m_acc});
    check("R3 accrued", {27'd0, rd_data[4:0]}, {27'd0, m_acc});
    check("R7 trap", {31'd0, trap_req}, {31'd0, m_trap});
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst = 1'b1; op_valid = 0; op_class = 0; op_exc = 0; cmp_unord = 0;
    trap_en = 0; sw_wr = 0; sw_wdata = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset word", rd_data, 32'd0);
    check("R1 reset trap", {31'd0, trap_req}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after release", rd_data, 32'd0);

    // R6: write all ones, reserved bits stay zero
    step(0, 0, 0, 0, 0, 1, 32'hFFFF_FFFF, "R6 masked write");
    check("R6 reserved", rd_data & 32'hFFFF_E0E0, 32'd0);
    // R8: collision
    step(1, 0, 5'b10001, 0, 5'b00000, 1, 32'h0000_0608, "R8 collision arith");
    step(1, 1, 5'b11111, 1, 5'b10000, 1, 32'h0000_0102, "R8 collision cmp");

    // Exhaustive sweep: class x unordered x exception pattern
    for (int c = 0; c < 4; c++) begin
      for (int u = 0; u < 2; u++) begin
        step(0, 0, 0, 0, 0, 1, 32'h0000_0000, "R6 clear");
        for (int e = 0; e < 32; e++) begin
          string t;
          t = (c == 0) ? "R2 arith" : (c == 1) ? "R4 ordered cmp" : "R5 silent class";
          step(1, 2'(c), 5'(e), 1'(u), 5'(e * 7 + c), 0, 32'd0, t);
        end
        step(0, 0, 5'h1F, 1, 5'h1F, 0, 32'd0, "R5 no valid");
      end
    end

    // R7: back-to-back traps then one with no enable overlap
    step(1, 0, 5'b00001, 0, 5'b00001, 0, 32'd0, "R7 trap a");
    step(1, 0, 5'b00100, 0, 5'b00100, 0, 32'd0, "R7 trap b");
    step(1, 0, 5'b00100, 0, 5'b00011, 0, 32'd0, "R7 no overlap");
    step(0, 0, 0, 0, 5'h1F, 0, 32'd0, "R7 idle");

    // R1: reset from a non-zero state
    step(0, 0, 0, 0, 0, 1, 32'h0000_1F1F, "R6 set all");
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R1 mid-run reset", rd_data, 32'd0);
    rst = 1'b0;
    finish_run();
  end
endmodule